// File: doc/BRIEF.md
# Programmable Johnson Divide-by-N Counter

A five-stage Johnson (twisted-ring) counter whose division ratio is chosen by a small select input. The shift chain moves one place per rising clock edge. The feedback bit that enters the first stage comes from one of three places: the inverted output of a tap stage (even ratios), the NAND of a tap stage and the stage below it (odd ratios), or a serial input pin that is used unchanged (external mode). A divided-clock output follows the tap stage.

Five jam bits can be loaded in parallel to preset the ring. A synchronous active-low reset clears it. An anti-lock rule watches the active part of the ring. When that part holds a pattern that is not a single contiguous run of ones, the rule injects zeros, so any start state drains back into the proper count cycle.

Top module: `jdiv_counter`

## Requirements
- R1: When rst_n is low at a rising edge, all five stages become 0 on that edge, whatever preset_en, jam, ser_in and ratio_sel are.
- R2: When rst_n is high and preset_en is high at a rising edge, stage i (q[i], i = 0..4) takes jam[i] on that edge, in every mode.
- R3: When rst_n is high and preset_en is low, every rising edge shifts the ring: q[i] takes the old q[i-1] for i = 1..4, and q[0] takes the feedback bit.
- R4: For an even ratio_sel value N in 2..10, with k = N/2, the feedback bit is the inverse of q[k-1]. From reset, div_out then repeats with a period of exactly N clocks and is high for N/2 of them.
- R5: For an odd ratio_sel value N in 3..9, with k = (N+1)/2, the feedback bit is NOT(q[k-1] AND q[k-2]). From reset, div_out then repeats with a period of exactly N clocks.
- R6: For any ratio_sel value outside 2..10 (external mode), q[0] takes ser_in on each counting edge, the anti-lock rule is off, and div_out equals q[4].
- R7: In internal modes div_out equals q[k-1], using the k of R4/R5.
- R8: In internal modes, when the active window q[k-1:0] has two or more positions where adjacent bits differ, the feedback bit is forced to 0.
- R9: In every internal ratio, from each of the 32 preset start states, after 5 counting edges the window q[k-1:0] lies in the legal cycle. For even N that is any pattern with at most one adjacent-bit change. For odd N it is the same set with the all-zero pattern left out.
- R10: In internal modes ser_in has no effect on the stages or on div_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| preset_en | input | 1 | Parallel load of the jam bits when high |
| jam | input | 5 | Preset value, bit i loads stage i |
| ser_in | input | 1 | Serial feedback input used in external mode |
| ratio_sel | input | 4 | Division ratio 2..10; other values select external mode |
| q | output | 5 | Stage states, q[0] is the first stage |
| div_out | output | 1 | Divided clock taken from the tap stage |

## Verification
The bench starts from each of the 32 stage patterns at every ratio and counts five edges. A design with a missing or mis-windowed anti-lock either circulates a broken pattern such as 0101 forever or corrupts the legal cycle. It measures the spacing of div_out rising edges per ratio. An off-by-one tap or a wrong NAND pair shows up as a period one or two clocks off, or as a lock-up in the all-ones or all-zeros state. It toggles ser_in during internal counting, where a leaking serial path would bend the sequence. It drives reset together with preset, and a priority error there loads the jam bits instead of clearing the ring.

// File: rtl/jdiv_pkg.sv
// Shared types for the programmable Johnson divider.
// Assumes the select code carries the ratio N directly.
package jdiv_pkg;

    typedef enum logic [1:0] {
        FB_EXT  = 2'd0,   // feedback from the serial pin
        FB_EVEN = 2'd1,   // inverted single tap
        FB_ODD  = 2'd2    // NAND of tap and the stage below
    } fb_mode_e;

endpackage

// File: rtl/jdiv_cfg_decode.sv
// Turns the ratio select value into a feedback mode and a tap index.
// Assumes ratios 2..2*STAGES are internal; anything else is external.
module jdiv_cfg_decode
    import jdiv_pkg::*;
#(
    parameter int STAGES = 5,
    parameter int SEL_W  = $clog2(2 * STAGES + 1),
    parameter int TAP_W  = $clog2(STAGES)
) (
    input  logic [SEL_W-1:0] sel,
    output fb_mode_e         mode,
    output logic [TAP_W-1:0] tap
);
    localparam int MAX_RATIO = 2 * STAGES;

    logic [SEL_W-1:0] half;

    // Map the ratio onto a mode and a zero-based tap index (k-1).
    always_comb begin
        half = (sel - SEL_W'(1)) >> 1;
        tap  = TAP_W'(half);
        if (int'(sel) >= 2 && int'(sel) <= MAX_RATIO) begin
            mode = sel[0] ? FB_ODD : FB_EVEN;
        end else begin
            mode = FB_EXT;
            tap  = TAP_W'(STAGES - 1);
        end
    end
endmodule

// File: rtl/jdiv_feedback.sv
// Forms the raw feedback bit for the first stage from the ring state.
// Assumes tap >= 1 whenever mode is odd.
module jdiv_feedback
    import jdiv_pkg::*;
#(
    parameter int STAGES = 5,
    parameter int TAP_W  = $clog2(STAGES)
) (
    input  logic [STAGES-1:0] q,
    input  logic              ser_in,
    input  fb_mode_e          mode,
    input  logic [TAP_W-1:0]  tap,
    output logic              tap_bit,
    output logic              low_bit,
    output logic              fb_raw
);
    // Select the tap stage and its lower neighbour without out-of-range indexing.
    always_comb begin
        tap_bit = 1'b0;
        low_bit = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (int'(tap) == i) tap_bit = q[i];
            if (int'(tap) == i + 1) low_bit = q[i];
        end
    end

    // Choose the feedback rule for the current mode.
    always_comb begin
        unique case (mode)
            FB_EVEN: fb_raw = ~tap_bit;
            FB_ODD:  fb_raw = ~(tap_bit & low_bit);
            default: fb_raw = ser_in;
        endcase
    end
endmodule

// File: rtl/jdiv_antilock.sv
// Detects broken ring patterns inside the active window and zeroes feedback.
// Assumes the window is stages 0..tap and is only checked in internal modes.
module jdiv_antilock
    import jdiv_pkg::*;
#(
    parameter int STAGES = 5,
    parameter int TAP_W  = $clog2(STAGES),
    parameter int CNT_W  = $clog2(STAGES) + 1
) (
    input  logic [STAGES-1:0] q,
    input  fb_mode_e          mode,
    input  logic [TAP_W-1:0]  tap,
    input  logic              fb_raw,
    output logic              broken,
    output logic              fb_fixed
);
    logic [STAGES-2:0] edge_at;
    logic [CNT_W-1:0]  edge_cnt;

    // Mark each adjacent pair inside the window whose bits differ.
    genvar g;
    generate
        for (g = 0; g < STAGES - 1; g++) begin : g_pair
            assign edge_at[g] = (g < int'(tap)) && (q[g] ^ q[g+1]);
        end
    endgenerate

    // Count the changes; two or more means the run of ones is not contiguous.
    always_comb begin
        edge_cnt = '0;
        for (int i = 0; i < STAGES - 1; i++) begin
            edge_cnt = edge_cnt + CNT_W'(edge_at[i]);
        end
        broken   = (mode != FB_EXT) && (edge_cnt >= CNT_W'(2));
        fb_fixed = broken ? 1'b0 : fb_raw;
    end
endmodule

// File: rtl/jdiv_stages.sv
// The shift chain: reset clears, preset loads jam bits, otherwise shifts.
// Assumes a synchronous active-low reset; reset outranks preset.
module jdiv_stages #(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [STAGES-1:0] jam,
    input  logic              fb_in,
    output logic [STAGES-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                // First stage: clear, load, or take the feedback bit.
                always_ff @(posedge clk) begin
                    if (!rst_n)       q[g] <= 1'b0;
                    else if (load_en) q[g] <= jam[g];
                    else              q[g] <= fb_in;
                end
            end else begin : g_body
                // Later stages: clear, load, or copy the stage below.
                always_ff @(posedge clk) begin
                    if (!rst_n)       q[g] <= 1'b0;
                    else if (load_en) q[g] <= jam[g];
                    else              q[g] <= q[g-1];
                end
            end
        end
    endgenerate

    // R2: a preset edge lands the jam bits in the stages.
    a_r2_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (q == $past(jam)));

    // R3: a counting edge moves every stage up by one place.
    a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (q[STAGES-1:1] == $past(q[STAGES-2:0])));
endmodule

// File: rtl/jdiv_counter.sv
// Programmable Johnson divide-by-N counter, ratio 2..2*STAGES.
// Assumes ratio_sel is held steady while counting for a clean divided clock.
module jdiv_counter
    import jdiv_pkg::*;
#(
    parameter int STAGES = 5,
    parameter int SEL_W  = $clog2(2 * STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_en,
    input  logic [STAGES-1:0] jam,
    input  logic              ser_in,
    input  logic [SEL_W-1:0]  ratio_sel,
    output logic [STAGES-1:0] q,
    output logic              div_out
);
    localparam int TAP_W = $clog2(STAGES);

    fb_mode_e         mode;
    logic [TAP_W-1:0] tap;
    logic             tap_bit;
    logic             low_bit;
    logic             fb_raw;
    logic             fb_fixed;
    logic             broken;

    jdiv_cfg_decode #(.STAGES(STAGES), .SEL_W(SEL_W), .TAP_W(TAP_W)) u_decode (
        .sel  (ratio_sel),
        .mode (mode),
        .tap  (tap)
    );

    jdiv_feedback #(.STAGES(STAGES), .TAP_W(TAP_W)) u_feedback (
        .q       (q),
        .ser_in  (ser_in),
        .mode    (mode),
        .tap     (tap),
        .tap_bit (tap_bit),
        .low_bit (low_bit),
        .fb_raw  (fb_raw)
    );

    jdiv_antilock #(.STAGES(STAGES), .TAP_W(TAP_W)) u_antilock (
        .q        (q),
        .mode     (mode),
        .tap      (tap),
        .fb_raw   (fb_raw),
        .broken   (broken),
        .fb_fixed (fb_fixed)
    );

    jdiv_stages #(.STAGES(STAGES)) u_stages (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (preset_en),
        .jam     (jam),
        .fb_in   (fb_fixed),
        .q       (q)
    );

    // The divided clock is the tap stage (the last stage in external mode).
    assign div_out = tap_bit;

    // R8: a broken window pushes a zero into the first stage.
    a_r8_antilock_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_en && broken) |=> (q[0] == 1'b0));

    // R4: even ratio with a clean window inverts the tap into the first stage.
    a_r4_even_twist: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_en && mode == FB_EVEN && !broken) |=> (q[0] == !$past(tap_bit)));

    // R5: odd ratio with a clean window feeds the NAND of tap and neighbour.
    a_r5_odd_nand: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_en && mode == FB_ODD && !broken) |=> (q[0] == !($past(tap_bit) && $past(low_bit))));

    // R6: external mode passes the serial pin straight into the first stage.
    a_r6_ext_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_en && mode == FB_EXT) |=> (q[0] == $past(ser_in)));
endmodule

// File: tb/test_jdiv_counter.sv
`timescale 1ns/1ps
module test_jdiv_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       preset_en = 1'b0;
    logic [4:0] jam = '0;
    logic       ser_in = 1'b0;
    logic [3:0] ratio_sel = 4'd10;
    logic [4:0] q;
    logic       div_out;

    int checks = 0;
    int errors = 0;
    logic [4:0] mstate = '0;

    typedef struct {
        logic [4:0] exp_q;
        logic       exp_div;
        string      tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    jdiv_counter i_jdiv_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset_en (preset_en),
        .jam       (jam),
        .ser_in    (ser_in),
        .ratio_sel (ratio_sel),
        .q         (q),
        .div_out   (div_out)
    );

    function automatic int kof(int n);
        return (n + 1) / 2;
    endfunction

    function automatic bit internal(int n);
        return (n >= 2 && n <= 10);
    endfunction

    // Reference next state written from R1..R8.
    function automatic logic [4:0] mnext(logic [4:0] s, logic rn, logic pre,
                                         logic [4:0] jv, logic sv, int n);
        logic fb;
        int   k;
        int   tr;
        if (!rn) return 5'b0;
        if (pre) return jv;
        if (!internal(n)) begin
            fb = sv;
        end else begin
            k  = kof(n);
            tr = 0;
            for (int i = 0; i < k - 1; i++) tr += int'(s[i] ^ s[i+1]);
            if (tr >= 2)         fb = 1'b0;
            else if (n % 2 == 0) fb = ~s[k-1];
            else                 fb = ~(s[k-1] & s[k-2]);
        end
        return {s[3:0], fb};
    endfunction

    function automatic logic mdiv(logic [4:0] s, int n);
        return internal(n) ? s[kof(n)-1] : s[4];
    endfunction

    // Driver: apply inputs, push the expected result, advance one edge.
    task automatic step(logic rn, logic pre, logic [4:0] jv, logic sv, int n, string tag);
        sb_item_t it;
        @(negedge clk);
        rst_n     = rn;
        preset_en = pre;
        jam       = jv;
        ser_in    = sv;
        ratio_sel = 4'(n);
        mstate    = mnext(mstate, rn, pre, jv, sv, n);
        it.exp_q   = mstate;
        it.exp_div = mdiv(mstate, n);
        it.tag     = tag;
        sb.push_back(it);
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare the design against the oldest expected item.
    always @(posedge clk) begin
        sb_item_t it;
        #1;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (q !== it.exp_q || div_out !== it.exp_div) begin
                errors++;
                $display("FAIL %s: q=%b div=%b expected q=%b div=%b",
                         it.tag, q, div_out, it.exp_q, it.exp_div);
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R4/R5/R7: measure div_out period (and even-ratio high time) from reset.
    task automatic run_ratio(int n);
        int last_rise = -1;
        int gap = -1;
        int highs = 0;
        logic prev;
        step(1'b0, 1'b0, 5'b0, 1'b0, n, "R1");
        prev = div_out;
        for (int c = 0; c < 4 * n; c++) begin
            step(1'b1, 1'b0, 5'b0, 1'($urandom_range(0, 1)), n, "R10 internal sequence");
            if (c >= 2 * n && div_out) highs++;
            if (div_out && !prev) begin
                if (last_rise >= 0) gap = c - last_rise;
                last_rise = c;
            end
            prev = div_out;
        end
        check(gap == n, (n % 2 == 0) ? "R4 period" : "R5 period", gap, n);
        if (n % 2 == 0) check(highs == n, "R4 duty over two periods", highs, n);
    endtask

    // R8/R9: every start state settles into the legal window set in 5 edges.
    task automatic antilock_sweep(int n);
        int k;
        int tr;
        bit ok;
        k = kof(n);
        for (int s = 0; s < 32; s++) begin
            step(1'b1, 1'b1, 5'(s), 1'b0, n, "R2 preset");
            for (int c = 0; c < 5; c++) step(1'b1, 1'b0, 5'b0, 1'b1, n, "R8 anti-lock step");
            tr = 0;
            for (int i = 0; i < k - 1; i++) tr += int'(q[i] ^ q[i+1]);
            ok = (tr <= 1);
            if (n % 2 == 1 && (q & 5'((1 << k) - 1)) == 0) ok = 0;
            check(ok, "R9 legal window after 5 edges", int'(q), s);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset wins over preset with all-ones jam bits.
        step(1'b0, 1'b1, 5'b11111, 1'b1, 10, "R1 reset over preset");
        step(1'b0, 1'b1, 5'b10101, 1'b0, 3, "R1 reset over preset");
        check(q == 5'b0, "R1 reset state", int'(q), 0);

        // R2: preset in internal and external modes.
        step(1'b1, 1'b1, 5'b10110, 1'b1, 7, "R2 preset internal");
        step(1'b1, 1'b1, 5'b01001, 1'b0, 0, "R2 preset external");
        check(q == 5'b01001, "R2 jam value", int'(q), 5'b01001);

        // R4/R5/R7/R10: every internal ratio.
        for (int n = 2; n <= 10; n++) run_ratio(n);

        // R10: same sequence with ser_in held high and held low.
        for (int v = 0; v < 2; v++) begin
            step(1'b0, 1'b0, 5'b0, 1'b0, 7, "R1");
            for (int c = 0; c < 9; c++) step(1'b1, 1'b0, 5'b0, 1'(v), 7, "R10 ser_in ignored");
        end

        // R6: external mode follows the serial pin, div_out = q[4].
        step(1'b0, 1'b0, 5'b0, 1'b0, 0, "R1");
        for (int c = 0; c < 12; c++) step(1'b1, 1'b0, 5'b0, 1'((c / 3) % 2), 0, "R6 external pass");
        for (int c = 0; c < 8; c++) step(1'b1, 1'b0, 5'b0, 1'(c % 2), 13, "R6 external code 13");
        step(1'b1, 1'b1, 5'b01010, 1'b0, 1, "R2 preset");
        for (int c = 0; c < 6; c++) step(1'b1, 1'b0, 5'b0, 1'b0, 1, "R6 no anti-lock in external");
        check(q == 5'b0, "R6 external drained pattern", int'(q), 0);

        // R8/R9: anti-lock from all 32 start states at every ratio.
        for (int n = 2; n <= 10; n++) antilock_sweep(n);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule